// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Chain

This block is the digital divide path of an integer-N frequency synthesizer. Everything runs on one system clock. The oscillator side and the crystal side arrive as single-cycle enable pulses, one per edge of each source.

On the oscillator side the path is a fixed halving stage, then a 32/33 dual-modulus prescaler. A swallow counter and a main counter steer that prescaler. Together they realise a 15-bit total ratio N, so one divided pulse leaves the chain every 2·N oscillator pulses. On the crystal side a reference counter divides by 64 or by 128.

A small phase/frequency detector compares the two divided edges and produces up/down pump requests and a lock flag. A test selector can route either the divided reference pulse or the halving-stage state to a test output.

Top module: `synth_divchain`

## Requirements
- R1: With ratio value N (legal range 1024 to 32767), `div_osc_pulse` is high for one cycle, one clock after every 2·N-th `osc_pulse`. N is split into a swallow part N[4:0] (periods of 33) and a main part N[14:5], with 32 for the remaining prescaler periods.
- R2: A new `n_ratio` takes effect only when a divided period completes, sampled in the cycle that completes it. The first period after reset always uses 1024.
- R3: The reference counter emits a pulse on every 128th `xtal_pulse` when `ref_fast` is 0 and on every 64th when it is 1. If the count already stands at or above the new terminal when `ref_fast` rises, the next `xtal_pulse` ends the period. `div_ref_pulse` is that pulse delayed by one clock.
- R4: A divided reference edge sets the up request and a divided oscillator edge sets the down request. When both have been seen, both requests clear in that cycle, so coincident edges raise neither request.
- R5: While `pump_off` is 1, `pump_up` and `pump_dn` are 0. The lock flag and the internal detector state are not affected.
- R6: `lock` rises after 4 consecutive comparisons whose two edges lie at most 2 clocks apart. It falls at the first comparison outside that window.
- R7: `test_out` is registered. With `test_en`=1 and `tmode_sel`=2'b00 it carries the divided reference pulse. With `tmode_sel`=2'b01 it carries the halving-stage state. For the other codes, or with `test_en`=0, it is 0.
- R8: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_pulse | input | 1 | One-cycle enable per oscillator edge |
| xtal_pulse | input | 1 | One-cycle enable per crystal edge |
| n_ratio | input | 15 | Total divide ratio N |
| ref_fast | input | 1 | Reference ratio: 0 = 128, 1 = 64 |
| pump_off | input | 1 | Forces pump requests inactive |
| test_en | input | 1 | Enables the test output |
| tmode_sel | input | 2 | Test source select |
| div_osc_pulse | output | 1 | Divided oscillator edge |
| div_ref_pulse | output | 1 | Divided reference edge |
| pump_up | output | 1 | Up request to the charge pump |
| pump_dn | output | 1 | Down request to the charge pump |
| lock | output | 1 | Lock flag |
| test_out | output | 1 | Test output |

## Verification
The spacing assertions assume that `n_ratio` stays within its legal range, so the oscillator divider never produces two pulses closer than 2048 oscillator pulses. They also assume that the reference ratio is at least 64. The stimulus only loads ratios between 1024 and 1100.

The lock-edge assertion relies on the detector only ever holding one pending request. It follows that any lock change coincides with a divided edge.

The stimulus runs two phases. One phase uses dense, aligned pulse trains so that the design reaches lock and then loses it through a ratio drift. The other phase uses pseudo-random pulse gaps with mid-count changes to the ratio, the reference speed and the test select.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    TSEL_REF  = 2'b00,
    TSEL_HALF = 2'b01,
    TSEL_RSV2 = 2'b10,
    TSEL_RSV3 = 2'b11
  } tsel_e;
endpackage

// File: rtl/sdc_osc_div.sv
module sdc_osc_div #(
  parameter int N_W       = 15,
  parameter int SW_W      = 5,
  parameter int RST_RATIO = 1024
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           osc_pulse,
  input  logic [N_W-1:0] n_ratio,
  output logic           osc_tick,
  output logic           half_q
);
  localparam int M_W  = N_W - SW_W;
  localparam int PC_W = SW_W + 1;
  localparam logic [PC_W-1:0] LAST_LO = PC_W'((1 << SW_W) - 1);
  localparam logic [PC_W-1:0] LAST_HI = PC_W'(1 << SW_W);
  localparam logic [M_W-1:0]  M_RST   = M_W'(RST_RATIO >> SW_W);
  localparam logic [SW_W-1:0] A_RST   = SW_W'(RST_RATIO % (1 << SW_W));

  logic            half_d;
  logic [PC_W-1:0] pre_q, pre_d, pre_last;
  logic [M_W-1:0]  m_cnt_q, m_cnt_d, m_lat_q, m_lat_d;
  logic [SW_W-1:0] a_lat_q, a_lat_d;

  // prescaler runs at 33 while the main count is below the swallow value
  always_comb begin
    half_d   = half_q;
    pre_d    = pre_q;
    m_cnt_d  = m_cnt_q;
    m_lat_d  = m_lat_q;
    a_lat_d  = a_lat_q;
    osc_tick = 1'b0;
    pre_last = (m_cnt_q < M_W'(a_lat_q)) ? LAST_HI : LAST_LO;
    if (osc_pulse) begin
      half_d = ~half_q;
      if (half_q) begin
        if (pre_q == pre_last) begin
          pre_d = '0;
          if (m_cnt_q == m_lat_q - M_W'(1)) begin
            m_cnt_d  = '0;
            m_lat_d  = n_ratio[N_W-1:SW_W];
            a_lat_d  = n_ratio[SW_W-1:0];
            osc_tick = 1'b1;
          end else begin
            m_cnt_d = m_cnt_q + M_W'(1);
          end
        end else begin
          pre_d = pre_q + PC_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      pre_q   <= '0;
      m_cnt_q <= '0;
      m_lat_q <= M_RST;
      a_lat_q <= A_RST;
    end else if (osc_pulse) begin
      half_q  <= half_d;
      pre_q   <= pre_d;
      m_cnt_q <= m_cnt_d;
      m_lat_q <= m_lat_d;
      a_lat_q <= a_lat_d;
    end
  end
endmodule

// File: rtl/sdc_ref_div.sv
module sdc_ref_div #(
  parameter int REF_LOG = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_pulse,
  input  logic ref_fast,
  output logic ref_tick
);
  localparam int REF_W = REF_LOG + 1;
  localparam logic [REF_W-1:0] TERM_FAST = REF_W'((1 << REF_LOG) - 1);
  localparam logic [REF_W-1:0] TERM_SLOW = REF_W'((1 << (REF_LOG + 1)) - 1);

  logic [REF_W-1:0] cnt_q, cnt_d, term;

  always_comb begin
    term     = ref_fast ? TERM_FAST : TERM_SLOW;
    ref_tick = xtal_pulse && (cnt_q >= term);
    cnt_d    = ref_tick ? '0 : cnt_q + REF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (xtal_pulse) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdc_pfd_lock.sv
module sdc_pfd_lock #(
  parameter int WIN      = 2,
  parameter int LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic osc_tick,
  output logic up_q,
  output logic dn_q,
  output logic lock_q
);
  localparam int SK_W = $clog2(WIN + 1);
  localparam int LK_W = $clog2(LOCK_CNT + 1);

  logic            up_n, dn_n, clr, pend, good;
  logic            up_d, dn_d, lock_d;
  logic [SK_W-1:0] sk_q, sk_d;
  logic [LK_W-1:0] gc_q, gc_d;

  always_comb begin
    up_n   = up_q | ref_tick;
    dn_n   = dn_q | osc_tick;
    clr    = up_n & dn_n;
    pend   = up_q | dn_q;
    good   = !pend || (sk_q < SK_W'(WIN));
    up_d   = up_n;
    dn_d   = dn_n;
    sk_d   = sk_q;
    gc_d   = gc_q;
    lock_d = lock_q;
    if (clr) begin
      up_d = 1'b0;
      dn_d = 1'b0;
      sk_d = '0;
      if (good) begin
        if (gc_q != LK_W'(LOCK_CNT)) gc_d = gc_q + LK_W'(1);
        lock_d = (gc_q >= LK_W'(LOCK_CNT - 1));
      end else begin
        gc_d   = '0;
        lock_d = 1'b0;
      end
    end else if (pend) begin
      if (sk_q != SK_W'(WIN)) sk_d = sk_q + SK_W'(1);
    end else begin
      sk_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      sk_q   <= '0;
      gc_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      up_q   <= up_d;
      dn_q   <= dn_d;
      sk_q   <= sk_d;
      gc_q   <= gc_d;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/synth_divchain.sv
module synth_divchain
  import sdc_pkg::*;
#(
  parameter int N_W       = 15,
  parameter int SW_W      = 5,
  parameter int RST_RATIO = 1024,
  parameter int REF_LOG   = 6,
  parameter int WIN       = 2,
  parameter int LOCK_CNT  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           osc_pulse,
  input  logic           xtal_pulse,
  input  logic [N_W-1:0] n_ratio,
  input  logic           ref_fast,
  input  logic           pump_off,
  input  logic           test_en,
  input  logic [1:0]     tmode_sel,
  output logic           div_osc_pulse,
  output logic           div_ref_pulse,
  output logic           pump_up,
  output logic           pump_dn,
  output logic           lock,
  output logic           test_out
);
  logic osc_tick, half_q, ref_tick, up_q, dn_q, test_d;

  sdc_osc_div #(.N_W(N_W), .SW_W(SW_W), .RST_RATIO(RST_RATIO)) u_osc (
    .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .n_ratio(n_ratio),
    .osc_tick(osc_tick), .half_q(half_q)
  );

  sdc_ref_div #(.REF_LOG(REF_LOG)) u_ref (
    .clk(clk), .rst_n(rst_n), .xtal_pulse(xtal_pulse), .ref_fast(ref_fast),
    .ref_tick(ref_tick)
  );

  sdc_pfd_lock #(.WIN(WIN), .LOCK_CNT(LOCK_CNT)) u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .osc_tick(osc_tick),
    .up_q(up_q), .dn_q(dn_q), .lock_q(lock)
  );

  always_comb begin
    test_d = 1'b0;
    if (test_en) begin
      case (tsel_e'(tmode_sel))
        TSEL_REF:  test_d = ref_tick;
        TSEL_HALF: test_d = half_q;
        default:   test_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_osc_pulse <= 1'b0;
      div_ref_pulse <= 1'b0;
      test_out      <= 1'b0;
    end else begin
      div_osc_pulse <= osc_tick;
      div_ref_pulse <= ref_tick;
      test_out      <= test_d;
    end
  end

  assign pump_up = up_q & ~pump_off;
  assign pump_dn = dn_q & ~pump_off;
endmodule

// File: rtl/sdc_chk.sv
module sdc_chk (
  input logic clk,
  input logic rst_n,
  input logic pump_off,
  input logic pump_up,
  input logic pump_dn,
  input logic test_en,
  input logic test_out,
  input logic div_osc_pulse,
  input logic div_ref_pulse,
  input logic lock
);
  AST_OSC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    div_osc_pulse |=> !div_osc_pulse); // R1
  AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    div_ref_pulse |=> !div_ref_pulse); // R3
  AST_PUMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn)); // R4
  AST_PUMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pump_off |-> (!pump_up && !pump_dn)); // R5
  AST_LOCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> (div_osc_pulse || div_ref_pulse)); // R6
  AST_TEST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> !test_out); // R7
endmodule

bind synth_divchain sdc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pump_off(pump_off), .pump_up(pump_up),
  .pump_dn(pump_dn), .test_en(test_en), .test_out(test_out),
  .div_osc_pulse(div_osc_pulse), .div_ref_pulse(div_ref_pulse), .lock(lock)
);

// File: tb/tb_synth_divchain.sv
module tb_synth_divchain;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_pulse = 1'b0, xtal_pulse = 1'b0;
  logic [14:0] n_ratio = 15'd1024;
  logic        ref_fast = 1'b1, pump_off = 1'b0, test_en = 1'b0;
  logic [1:0]  tmode_sel = 2'b00;
  logic        div_osc_pulse, div_ref_pulse, pump_up, pump_dn, lock, test_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  synth_divchain dut (
    .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .xtal_pulse(xtal_pulse),
    .n_ratio(n_ratio), .ref_fast(ref_fast), .pump_off(pump_off),
    .test_en(test_en), .tmode_sel(tmode_sel), .div_osc_pulse(div_osc_pulse),
    .div_ref_pulse(div_ref_pulse), .pump_up(pump_up), .pump_dn(pump_dn),
    .lock(lock), .test_out(test_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  oc, lat, rc, pend_t, good_n, cyc;
  bit  h, th, up_m, dn_m, lk, ot, rt;
  bit  e_osc, e_ref, e_test;
  always @(posedge clk) begin
    if (!rst_n) begin
      oc = 0; lat = 1024; rc = 0; pend_t = 0; good_n = 0; cyc = 0;
      h = 0; up_m = 0; dn_m = 0; lk = 0;
      e_osc = 0; e_ref = 0; e_test = 0;
    end else begin
      th = h; ot = 0; rt = 0;
      if (osc_pulse) begin
        h = ~h; oc++;
        if (oc == 2 * lat) begin ot = 1; oc = 0; lat = n_ratio; end
      end
      if (xtal_pulse) begin
        if (rc >= (ref_fast ? 64 : 128) - 1) begin rt = 1; rc = 0; end
        else rc++;
      end
      if ((up_m | rt) && (dn_m | ot)) begin
        if (!(up_m | dn_m) || (cyc - pend_t) <= 2) begin good_n++; lk = (good_n >= 4); end
        else begin good_n = 0; lk = 0; end
        up_m = 0; dn_m = 0;
      end else begin
        if (!(up_m | dn_m) && (rt | ot)) pend_t = cyc;
        up_m = up_m | rt; dn_m = dn_m | ot;
      end
      e_osc = ot; e_ref = rt;
      e_test = test_en && ((tmode_sel == 2'b00) ? rt : (tmode_sel == 2'b01) ? th : 1'b0);
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(div_osc_pulse == e_osc, "R1", div_osc_pulse, e_osc);
      check(div_ref_pulse == e_ref, "R3", div_ref_pulse, e_ref);
      check(pump_up == (up_m && !pump_off), "R4", pump_up, up_m && !pump_off);
      check(pump_dn == (dn_m && !pump_off), "R4", pump_dn, dn_m && !pump_off);
      check(lock == lk, "R6", lock, lk);
      check(test_out == e_test, "R7", test_out, e_test);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0; osc_pulse = 0; xtal_pulse = 0;
    repeat (4) @(negedge clk);
    check({div_osc_pulse, div_ref_pulse, pump_up, pump_dn, lock, test_out} == 6'b0,
          "R8", {div_osc_pulse, div_ref_pulse, pump_up, pump_dn, lock, test_out}, 0);
    #1;
  endtask

  task automatic aligned_run(input int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      osc_pulse = 1'b1;
      xtal_pulse = ((i % 32) == 31);
      step();
    end
  endtask

  logic [31:0] lf = 32'h1ACE_B00C;
  task automatic nxt();
    lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
  endtask

  initial begin
    int k;
    // R2: first period uses 1024 regardless of n_ratio, then the new value
    n_ratio = 15'd1500;
    do_reset();
    rst_n = 1'b1; osc_pulse = 1'b1;
    k = 0;
    while (k < 5000) begin @(negedge clk); k++; if (div_osc_pulse) break; end
    check(k == 2048, "R2", k, 2048);
    #1; k = 0;
    while (k < 5000) begin @(negedge clk); k++; if (div_osc_pulse) break; end
    check(k == 3000, "R2", k, 3000);
    #1;

    // R6: aligned trains reach lock
    n_ratio = 15'd1024; ref_fast = 1'b1;
    do_reset();
    rst_n = 1'b1;
    aligned_run(12288);
    check(lock == 1'b1, "R6", lock, 1);

    // R5: pump forced off, lock untouched
    pump_off = 1'b1;
    for (int i = 12288; i < 16384; i++) begin
      osc_pulse = 1'b1; xtal_pulse = ((i % 32) == 31);
      check(!pump_up && !pump_dn, "R5", pump_up | pump_dn, 0);
      step();
    end
    check(lock == 1'b1, "R5", lock, 1);
    pump_off = 1'b0;

    // R2/R6: ratio drift loses lock
    n_ratio = 15'd1025;
    for (int i = 16384; i < 28672; i++) begin
      osc_pulse = 1'b1; xtal_pulse = ((i % 32) == 31);
      step();
    end
    check(lock == 1'b0, "R6", lock, 0);

    // R3/R7: irregular pulses, mode changes mid-count
    for (int i = 0; i < 30000; i++) begin
      nxt();
      osc_pulse  = lf[0] | lf[1];
      xtal_pulse = lf[2];
      if ((i % 700) == 0) n_ratio = 15'd1024 + 15'(lf[10:5] % 77);
      if ((i % 333) == 0) ref_fast = lf[11];
      if ((i % 250) == 0) begin test_en = lf[12]; tmode_sel = lf[14:13]; end
      if ((i % 900) == 0) pump_off = lf[15] & lf[16];
      step();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule